// File: doc/BRIEF.md
# Bus-Activity Watchdog Reset Timer

This block supervises a processor by watching the two wires of its serial bus. Each start condition on the bus (data falling while clock is high) counts as the processor's sign of life and restarts a timeout counter. If the counter runs through the selected interval with no start condition, the block drives a reset for a fixed number of timebase ticks. It then begins timing again from zero. The bus wires are asynchronous to the system clock, so they pass through two-flop synchronizers before the edge detector looks at them.

The interval comes from a two-bit select that a control register supplies. Three codes choose a short, a medium or a long interval. The fourth code switches the watchdog off. All timing is counted in ticks of an external prescaled timebase. The tick counts are parameters, so a small bench can use short intervals. A synchronous power-on reset input holds the reset outputs active. After that input is released, the outputs stay active for the fixed reset period. While the reset outputs are active, activity on the bus has no effect.

Top module: `bus_watchdog`

## Requirements
- R1: A start condition restarts the timeout. A start condition is sda_i falling while scl_i is high, as seen after a two-flop synchronizer on each wire. A reset is then asserted only after a full interval of ticks with no further start condition.
- R2: sda_i falling while scl_i is low is not a start condition and does not restart the timeout.
- R3: The select codes choose the interval. 2'b00 chooses SHORT_TICKS, 2'b01 chooses MED_TICKS and 2'b10 chooses LONG_TICKS. The reset outputs become active on the Nth tick after the last restart, where N is the selected count.
- R4: Select code 2'b11 turns the watchdog off. While this code is applied, no timeout ever asserts the reset outputs.
- R5: Each reset pulse lasts exactly HOLD_TICKS ticks. The outputs are released on the edge that consumes the last of those ticks.
- R6: While the power-on reset input rst is high, wdt_rst_o is 1 and wdt_rst_n_o is 0. After rst falls, the outputs stay active for HOLD_TICKS ticks.
- R7: Start conditions that arrive while the reset outputs are active are ignored. After the pulse ends, the timeout counts a full interval from the release.
- R8: wdt_rst_n_o is always the inverse of wdt_rst_o.
- R9: A start condition that reaches the counter on the same clock as the interval's final tick wins. No reset is asserted, and a fresh full interval begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_i | input | 1 | Serial bus clock wire, asynchronous |
| sda_i | input | 1 | Serial bus data wire, asynchronous |
| interval_sel_i | input | 2 | Interval select: 00 short, 01 medium, 10 long, 11 off |
| tick_i | input | 1 | One-clock timebase pulse that advances all counts |
| wdt_rst_o | output | 1 | Reset output, active high |
| wdt_rst_n_o | output | 1 | Reset output, active low |

## Verification
Restarting and expiring can land on the same clock edge. This happens when the synchronized start condition reaches the counter in the very cycle that carries the interval's final tick. The bench provokes this by lowering the data wire two clocks after the preceding tick was raised. Through the synchronizer and edge detector, the kick then lands exactly on the expiring tick. The scoreboard expects no reset at that edge. It then expects a timeout a full long interval later, which also shows that the counter came back from zero rather than from a stale value.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Interval select codes; the off code is part of the behaviour.
    typedef enum logic [1:0] {
        WIN_SHORT = 2'b00,
        WIN_MED   = 2'b01,
        WIN_LONG  = 2'b10,
        WIN_OFF   = 2'b11
    } win_sel_e;

    // Sampled state of the two bus wires.
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_pins_t;

    // Output phase of the reset generator.
    typedef enum logic {
        PH_WATCH = 1'b0,
        PH_HOLD  = 1'b1
    } phase_e;

    function automatic int unsigned win_ticks(
        input win_sel_e    sel,
        input int unsigned t_short,
        input int unsigned t_med,
        input int unsigned t_long
    );
        case (sel)
            WIN_SHORT: return t_short;
            WIN_MED:   return t_med;
            WIN_LONG:  return t_long;
            default:   return 0;
        endcase
    endfunction

    function automatic logic win_enabled(input win_sel_e sel);
        return sel != WIN_OFF;
    endfunction

    function automatic int unsigned max3(
        input int unsigned a,
        input int unsigned b,
        input int unsigned c
    );
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync
    import wdg_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_pins_t pins_i,
    output bus_pins_t pins_o
);
    localparam int unsigned NBITS = $bits(bus_pins_t);

    logic [NBITS-1:0] d_vec;
    logic [NBITS-1:0] q_vec;

    assign d_vec  = pins_i;
    assign pins_o = q_vec;

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        logic [STAGES-1:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) begin
                shreg <= '1;  // idle bus level
            end else begin
                shreg <= {shreg[STAGES-2:0], d_vec[b]};
            end
        end
        assign q_vec[b] = shreg[STAGES-1];
    end

endmodule

// File: rtl/wdg_start_det.sv
module wdg_start_det
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable_i,
    input  bus_pins_t pins_i,
    output logic      start_o
);
    bus_pins_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '1;
        end else begin
            prev_q <= pins_i;
        end
    end

    // Data falling while the clock wire is high in both samples.
    assign start_o = enable_i
                   & prev_q.scl & pins_i.scl
                   & prev_q.sda & ~pins_i.sda;

endmodule

// File: rtl/wdg_interval_timer.sv
module wdg_interval_timer
    import wdg_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 200,
    parameter int unsigned MED_TICKS   = 600,
    parameter int unsigned LONG_TICKS  = 1400
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hold_i,
    input  win_sel_e sel_i,
    input  logic     tick_i,
    input  logic     kick_i,
    output logic     expire_o
);
    localparam int unsigned MAXT = max3(SHORT_TICKS, MED_TICKS, LONG_TICKS);
    localparam int unsigned CW   = $clog2(MAXT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_idx;
    int unsigned   limit;
    logic          running;

    always_comb begin
        limit    = win_ticks(sel_i, SHORT_TICKS, MED_TICKS, LONG_TICKS);
        last_idx = CW'(limit - 1);
        running  = win_enabled(sel_i) & ~hold_i;
        // A kick on the final tick takes priority over expiry.
        expire_o = running & tick_i & ~kick_i & (cnt_q >= last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst || !running || kick_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (expire_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdg_reset_pulse.sv
module wdg_reset_pulse
    import wdg_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 200
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   fire_i,
    output phase_e phase_o
);
    localparam int unsigned RW = $clog2(HOLD_TICKS + 1);
    localparam logic [RW-1:0] LAST = RW'(HOLD_TICKS - 1);

    phase_e        phase_q;
    logic [RW-1:0] rcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            rcnt_q  <= '0;
        end else begin
            case (phase_q)
                PH_HOLD: begin
                    if (tick_i) begin
                        if (rcnt_q == LAST) begin
                            phase_q <= PH_WATCH;
                            rcnt_q  <= '0;
                        end else begin
                            rcnt_q <= rcnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (fire_i) begin
                        phase_q <= PH_HOLD;
                        rcnt_q  <= '0;
                    end
                end
            endcase
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 200,
    parameter int unsigned MED_TICKS   = 600,
    parameter int unsigned LONG_TICKS  = 1400,
    parameter int unsigned HOLD_TICKS  = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] interval_sel_i,
    input  logic       tick_i,
    output logic       wdt_rst_o,
    output logic       wdt_rst_n_o
);
    bus_pins_t pins_raw;
    bus_pins_t pins_sync;
    phase_e    phase;
    logic      hold;
    logic      kick;
    logic      expire;
    win_sel_e  sel;

    assign pins_raw.scl = scl_i;
    assign pins_raw.sda = sda_i;
    assign sel          = win_sel_e'(interval_sel_i);
    assign hold         = (phase == PH_HOLD);

    wdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_raw),
        .pins_o (pins_sync)
    );

    wdg_start_det u_start (
        .clk      (clk),
        .rst      (rst),
        .enable_i (~hold),
        .pins_i   (pins_sync),
        .start_o  (kick)
    );

    wdg_interval_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .MED_TICKS   (MED_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (hold),
        .sel_i    (sel),
        .tick_i   (tick_i),
        .kick_i   (kick),
        .expire_o (expire)
    );

    wdg_reset_pulse #(.HOLD_TICKS(HOLD_TICKS)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .fire_i  (expire),
        .phase_o (phase)
    );

    assign wdt_rst_o   = hold;
    assign wdt_rst_n_o = ~hold;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic [1:0] sel_i,
    input logic       kick_i,
    input logic       rst_o,
    input logic       rst_n_o
);
    // R8
    assert_outputs_complement_R8: assert property (@(posedge clk) disable iff (rst)
        rst_o != rst_n_o);

    // R6
    assert_por_hold_R6: assert property (@(posedge clk)
        rst |=> rst_o);

    // R3
    assert_expire_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_o) |-> $past(tick_i));

    // R5
    assert_release_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_o) |-> $past(tick_i));

    // R4
    assert_off_no_reset_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 2'b11 && !rst_o) |=> !rst_o);

    // R9
    assert_kick_beats_expiry_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_o) |-> !$past(kick_i));

    // R1
    assert_kick_holds_off_R1: assert property (@(posedge clk) disable iff (rst)
        (kick_i && !rst_o) |=> !rst_o);

endmodule

bind bus_watchdog wdg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .sel_i   (interval_sel_i),
    .kick_i  (kick),
    .rst_o   (wdt_rst_o),
    .rst_n_o (wdt_rst_n_o)
);

// File: tb/sim_bus_watchdog.sv
module sim_bus_watchdog;
    localparam int T_SHORT = 4;
    localparam int T_MED   = 6;
    localparam int T_LONG  = 9;
    localparam int T_HOLD  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       tick = 1'b0;
    logic       wdt_rst_o;
    logic       wdt_rst_n_o;

    int checks   = 0;
    int failures = 0;
    int div      = 0;
    int kick_dly = 0;
    int tcnt     = 0;
    logic prev_o = 1'b1;
    bit done     = 1'b0;

    typedef struct {
        bit    is_pulse;
        int    ticks;
        string req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;  // 125 MHz

    bus_watchdog #(
        .SHORT_TICKS (T_SHORT),
        .MED_TICKS   (T_MED),
        .LONG_TICKS  (T_LONG),
        .HOLD_TICKS  (T_HOLD)
    ) u0 (
        .clk            (clk),
        .rst            (rst),
        .scl_i          (scl),
        .sda_i          (sda),
        .interval_sel_i (sel),
        .tick_i         (tick),
        .wdt_rst_o      (wdt_rst_o),
        .wdt_rst_n_o    (wdt_rst_n_o)
    );

    // Timebase: one tick every fourth clock, changed at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            div  = (div + 1) % 4;
            tick = (div == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input bit is_pulse, input int ticks, input string req);
        exp_t e;
        e.is_pulse = is_pulse;
        e.ticks    = ticks;
        e.req      = req;
        sb.push_back(e);
    endtask

    task automatic score(input bit is_pulse);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, is_pulse ? "R5 unexpected release" : "R4 unexpected reset", tcnt, -1);
        end else begin
            e = sb.pop_front();
            check(e.is_pulse == is_pulse, {e.req, " event kind"}, int'(is_pulse), int'(e.is_pulse));
            check(tcnt == e.ticks, {e.req, " tick count"}, tcnt, e.ticks);
        end
    endtask

    // Monitor: measures ticks between anchors and output edges.
    always @(posedge clk) begin
        #2;
        if (rst) begin
            tcnt     = 0;
            kick_dly = 0;
        end else begin
            if (tick) tcnt++;
            if (kick_dly > 0) begin
                kick_dly--;
                if (kick_dly == 0) tcnt = 0;
            end
            check(wdt_rst_o != wdt_rst_n_o, "R8 complement", int'(wdt_rst_n_o), int'(~wdt_rst_o));
            if (wdt_rst_o && !prev_o) begin
                score(1'b0);
                tcnt = 0;
            end else if (!wdt_rst_o && prev_o) begin
                score(1'b1);
                tcnt = 0;
            end
        end
        prev_o = wdt_rst_o;
    end

    task automatic wait_tick_sets(input int n);
        repeat (n) begin
            do begin
                @(negedge clk);
                #1;
            end while (!tick);
        end
    endtask

    // Start condition: SDA falls with SCL high, then a stop returns SDA high.
    task automatic kick(input bit counts, input int off);
        wait_tick_sets(1);
        repeat (off) @(negedge clk);
        sda = 1'b0;
        if (counts) kick_dly = 3;
        repeat (2) @(negedge clk);
        sda = 1'b1;
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (!wdt_rst_o);
    endtask

    task automatic wait_fall();
        do @(negedge clk); while (wdt_rst_o);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(wdt_rst_o == 1'b1 && wdt_rst_n_o == 1'b0, "R6 reset state", int'(wdt_rst_o), 1);
        push(1'b1, T_HOLD,  "R6");
        push(1'b0, T_SHORT, "R3 short");
        push(1'b1, T_HOLD,  "R5");
        rst = 1'b0;
        wait_fall();
        wait_rise();
        // During the pulse: a start must be ignored; switch to medium.
        sel = 2'b01;
        kick(1'b0, 0);
        push(1'b0, T_MED,  "R7 fresh after pulse");
        push(1'b1, T_HOLD, "R5");
        wait_fall();
        wait_rise();
        wait_fall();

        // Long interval with periodic kicks.
        sel = 2'b10;
        kick(1'b1, 0);
        wait_tick_sets(5);
        kick(1'b1, 0);
        wait_tick_sets(5);
        kick(1'b1, 0);
        wait_tick_sets(5);
        check(wdt_rst_o == 1'b0, "R1 kicks hold off reset", int'(wdt_rst_o), 0);
        kick(1'b1, 0);
        // Kick lands on the expiring ninth tick.
        wait_tick_sets(7);
        push(1'b0, T_LONG, "R9 fresh after coincident kick");
        push(1'b1, T_HOLD, "R5");
        kick(1'b1, 2);
        repeat (2) @(negedge clk);
        check(wdt_rst_o == 1'b0, "R9 no reset on coincident kick", int'(wdt_rst_o), 0);
        wait_rise();
        wait_fall();

        // SDA falls while SCL is low: not a start.
        sel = 2'b00;
        push(1'b0, T_SHORT, "R2 no restart with SCL low");
        push(1'b1, T_HOLD,  "R5");
        wait_tick_sets(2);
        scl = 1'b0;
        @(negedge clk);
        sda = 1'b0;
        repeat (2) @(negedge clk);
        sda = 1'b1;
        @(negedge clk);
        scl = 1'b1;
        wait_rise();
        wait_fall();

        // Off code.
        sel = 2'b11;
        wait_tick_sets(30);
        check(wdt_rst_o == 1'b0, "R4 off code never resets", int'(wdt_rst_o), 0);
        sel = 2'b00;
        kick(1'b1, 0);
        push(1'b0, T_SHORT, "R3 short after re-enable");
        push(1'b1, T_HOLD,  "R5");
        wait_rise();
        wait_fall();
        repeat (8) @(negedge clk);
        check(sb.size() == 0, "R5 all expected events seen", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule